// File: doc/BRIEF.md
# Page-Write EEPROM Bus Front End

This block is a clocked model of a byte-wide, page-write nonvolatile memory as a host sees it over a parallel bus. The host drives active-low chip-select, write-strobe and output-enable lines together with an address and a data byte. The block brings those strobes into its clock domain and combines chip-select and write-strobe into one effective write strobe. It captures each written byte, watches for a three-byte unlock command, and gathers up to one page of bytes in a page buffer.

When no new write strobe arrives for a set number of clock ticks, page loading stops. A timed internal program cycle then writes the whole page into an array held in registers. Buffer slots that the host never loaded are stored as all-ones. While that cycle runs, the bus accepts no writes and a read returns a busy status byte in place of array data.

Once the unlock command has been seen, the device stays write-protected. Every later page write must be preceded by the same command, and protection is back in force as soon as that page is committed. The array size, the page size, the timeouts and the unlock pattern are parameters.

Top module: `pw_eeprom`

## Requirements
- R1: `dataOe` is high only while both `ceN` and `oeN` are low, as seen after a two-flop synchroniser, and `dataOut` is zero whenever `dataOe` is low. When the block is idle or loading, `dataOut` is the array byte at `addr`.
- R2: After reset every array byte reads 8'hFF, protection is off, and `dataOe` is low.
- R3: While protection is off, a write that is not the first byte of the unlock command opens a page load, and that byte is the first one loaded.
- R4: The unlock command is three writes in this order: 8'hAA to address 9'h155, 8'h55 to 9'h0AA, and 8'hA0 to 9'h155. Completing it turns protection on and opens a page load. The command bytes themselves are never stored.
- R5: While protection is on, a write that is not part of a complete unlock command is ignored, and the array is left unchanged. A wrong byte in the middle of the command aborts it.
- R6: Loading a second byte at a page offset that already holds one replaces the earlier value.
- R7: If LOAD_TICKS clocks pass with no write strobe, page loading ends. A program cycle of PROG_TICKS clocks then follows, and at its end the whole page is written in a single cycle. Before that moment the array still reads its old contents.
- R8: The page written is the page (address bits above the 7-bit offset) of the last byte loaded. All buffered bytes go to that page.
- R9: A page offset that received no byte during the load is written as 8'hFF.
- R10: During the program cycle, a read returns a status byte and not array data. Bit 7 of the status byte is the inverse of bit 7 of the last loaded byte, and bits 6..0 are zero. Writes made during the program cycle are discarded.
- R11: Once protection has been turned on, it stays on. A write without the unlock command after a page write is ignored.
- R12: The address is captured when the effective write strobe (chip-select and write-strobe both low) becomes active. The data is captured when that strobe ends. Address or data changes outside those moments have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; upper bits select the page |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or busy status, zero when not driven |
| dataOe | output | 1 | High when the bus would be driven |

## Verification
The bench targets four corner cases:

- **Bytes that must not reach the array.** This covers the unlock command bytes, writes while protected, an aborted command, and writes made during the program cycle. A design that stored any of them would corrupt a page, and the final sweep of all 512 bytes catches that.
- **Content of a partially loaded page.** The bench loads a page with an overwritten offset, and separately a page whose bytes were addressed to two different pages. A design that kept stale bytes in place of 8'hFF, or that used the first page seen, would leave the wrong values in the array.
- **Timing of commit and status reads.** Reads during page loading must still return old data, and reads during the program cycle must return the status byte. A design that committed early, or that returned array data while busy, fails there.
- **Bus sampling.** Every write scrambles the address after the strobe starts and scrambles the data after it ends. A design that sampled either at the wrong edge would write garbage.

// File: rtl/pw_eeprom_pkg.sv
package pw_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEQ1,
    ST_SEQ2,
    ST_LOAD,
    ST_PROG
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;   // latch bus address
    logic capData;   // latch bus data
    logic loadByte;  // store latched byte in page buffer
    logic commit;    // write page buffer into array
    logic busy;      // program cycle running
  } ctrlStrb_t;

endpackage

// File: rtl/pw_eeprom_ctrl.sv
module pw_eeprom_ctrl
  import pw_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned LOAD_TICKS = 40,
  parameter int unsigned PROG_TICKS = 100,
  parameter logic [ADDR_W-1:0] UNLOCK_A1 = 9'h155,
  parameter logic [ADDR_W-1:0] UNLOCK_A2 = 9'h0AA,
  parameter logic [7:0] UNLOCK_D1 = 8'hAA,
  parameter logic [7:0] UNLOCK_D2 = 8'h55,
  parameter logic [7:0] UNLOCK_D3 = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] latAddr,
  input  logic [7:0]        latData,
  input  logic              anyValid,
  output ctrlStrb_t         strb,
  output logic              readEn
);

  localparam int unsigned MAX_T = (LOAD_TICKS > PROG_TICKS) ? LOAD_TICKS : PROG_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_TICKS - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_TICKS - 1);

  logic [1:0] ceSh, weSh, oeSh;
  logic       wrAct, wrActQ, fallEdge, riseEdge, evtPend;
  ctrlState_t state, stateN;
  logic       protEn, protN;
  logic [CNT_W-1:0] timer, timerN;
  logic       loadByte, commit;
  logic       m1, m2, m3, loadDone, progDone;

  // two-flop synchronisers, strobes idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSh <= 2'b11;
      weSh <= 2'b11;
      oeSh <= 2'b11;
    end else begin
      ceSh <= {ceSh[0], ceN};
      weSh <= {weSh[0], weN};
      oeSh <= {oeSh[0], oeN};
    end
  end

  assign wrAct    = ~ceSh[1] & ~weSh[1];
  assign readEn   = ~ceSh[1] & ~oeSh[1];
  assign fallEdge = wrAct & ~wrActQ;
  assign riseEdge = ~wrAct & wrActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ  <= 1'b0;
      evtPend <= 1'b0;
    end else begin
      wrActQ  <= wrAct;
      evtPend <= riseEdge;  // latched byte valid one cycle later
    end
  end

  assign m1 = (latAddr == UNLOCK_A1) && (latData == UNLOCK_D1);
  assign m2 = (latAddr == UNLOCK_A2) && (latData == UNLOCK_D2);
  assign m3 = (latAddr == UNLOCK_A1) && (latData == UNLOCK_D3);
  assign loadDone = (timer == LOAD_LAST);
  assign progDone = (timer == PROG_LAST);

  always_comb begin
    stateN   = state;
    protN    = protEn;
    timerN   = timer;
    loadByte = 1'b0;
    commit   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        timerN = '0;
        if (evtPend) begin
          if (m1) begin
            stateN = ST_SEQ1;
          end else if (!protEn) begin
            loadByte = 1'b1;
            stateN   = ST_LOAD;
          end
        end
      end
      ST_SEQ1, ST_SEQ2: begin
        if (evtPend) begin
          timerN = '0;
          if (state == ST_SEQ1 && m2) begin
            stateN = ST_SEQ2;
          end else if (state == ST_SEQ2 && m3) begin
            stateN = ST_LOAD;
            protN  = 1'b1;
          end else begin
            stateN = ST_IDLE;
          end
        end else if (wrAct) begin
          timerN = '0;
        end else if (loadDone) begin
          stateN = ST_IDLE;
          timerN = '0;
        end else begin
          timerN = timer + CNT_W'(1);
        end
      end
      ST_LOAD: begin
        if (evtPend) begin
          loadByte = 1'b1;
          timerN   = '0;
        end else if (wrAct) begin
          timerN = '0;
        end else if (loadDone) begin
          stateN = anyValid ? ST_PROG : ST_IDLE;
          timerN = '0;
        end else begin
          timerN = timer + CNT_W'(1);
        end
      end
      ST_PROG: begin
        if (progDone) begin
          commit = 1'b1;
          stateN = ST_IDLE;
          timerN = '0;
        end else begin
          timerN = timer + CNT_W'(1);
        end
      end
      default: begin
        stateN = ST_IDLE;
        timerN = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      protEn <= 1'b0;
      timer  <= '0;
    end else begin
      state  <= stateN;
      protEn <= protN;
      timer  <= timerN;
    end
  end

  assign strb.capAddr  = fallEdge;
  assign strb.capData  = riseEdge;
  assign strb.loadByte = loadByte;
  assign strb.commit   = commit;
  assign strb.busy     = (state == ST_PROG);

  a_r5_locked_idle_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && protEn) |-> !strb.loadByte);
  a_r10_busy_no_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> !strb.loadByte);
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadByte, strb.commit}));
  a_r11_protect_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(protEn) |-> protEn);

endmodule

// File: rtl/pw_eeprom_dp.sv
module pw_eeprom_dp
  import pw_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned OFS_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic [ADDR_W-1:0] latAddr,
  output logic [7:0]        latData,
  output logic              anyValid,
  output logic [7:0]        readData
);

  localparam int unsigned PAGE_BYTES = 1 << OFS_W;
  localparam int unsigned PAGE_W     = ADDR_W - OFS_W;
  localparam int unsigned MEM_BYTES  = 1 << ADDR_W;

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validQ;
  logic [PAGE_W-1:0]     pageQ;
  logic                  pollBit;
  logic [7:0]            mem [MEM_BYTES];
  logic [OFS_W-1:0]      latOfs;

  assign latOfs   = latAddr[OFS_W-1:0];
  assign anyValid = |validQ;

  // bus capture registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else begin
      if (strb.capAddr) latAddr <= addrIn;
      if (strb.capData) latData <= dataIn;
    end
  end

  // page buffer, valid flags and target page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      pageQ   <= '0;
      pollBit <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'hFF;
    end else if (strb.commit) begin
      validQ <= '0;
    end else if (strb.loadByte) begin
      pageBuf[latOfs] <= latData;
      validQ[latOfs]  <= 1'b1;
      pageQ           <= latAddr[ADDR_W-1:OFS_W];
      pollBit         <= ~latData[7];
    end
  end

  // array: whole page written in one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strb.commit) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        if (PAGE_W'(i >> OFS_W) == pageQ) begin
          mem[i] <= validQ[OFS_W'(i)] ? pageBuf[OFS_W'(i)] : 8'hFF;
        end
      end
    end
  end

  assign readData = strb.busy ? {pollBit, 7'b0} : mem[addrIn];

  a_r7_commit_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> anyValid);
  a_r7_prog_entry_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.busy) |-> anyValid);

endmodule

// File: rtl/pw_eeprom.sv
module pw_eeprom
  import pw_eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned OFS_W      = 7,
  parameter int unsigned LOAD_TICKS = 40,
  parameter int unsigned PROG_TICKS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] latAddr;
  logic [7:0]        latData;
  logic              anyValid;
  logic [7:0]        readData;

  pw_eeprom_ctrl #(
    .ADDR_W(ADDR_W), .LOAD_TICKS(LOAD_TICKS), .PROG_TICKS(PROG_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .latAddr(latAddr), .latData(latData), .anyValid(anyValid),
    .strb(strb), .readEn(dataOe)
  );

  pw_eeprom_dp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addr), .dataIn(dataIn),
    .latAddr(latAddr), .latData(latData), .anyValid(anyValid),
    .readData(readData)
  );

  assign dataOut = dataOe ? readData : 8'h00;

  a_r1_drive_needs_strobes: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!$past(ceN, 2) && !$past(oeN, 2)));

endmodule

// File: tb/test_pw_eeprom.sv
module test_pw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int LOAD_T = 40;
  localparam int PROG_T = 100;
  localparam int NBYTES = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [8:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] model [NBYTES];
  logic [7:0] pb [128];
  logic       pv [128];
  logic [1:0] lastPage;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_eeprom #(.LOAD_TICKS(LOAD_T), .PROG_TICKS(PROG_T)) i_pw_eeprom (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // address scrambled after strobe start, data scrambled after strobe end (R12)
  task automatic busWrite(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 1'b0; weN = 1'b0;
    waitCyc(5);
    addr = ~a; dataIn = d;
    waitCyc(2);
    weN = 1'b1; ceN = 1'b1;
    waitCyc(5);
    dataIn = ~d;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    waitCyc(4);
    d = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    waitCyc(3);
  endtask

  task automatic readCheck(input string tag, input logic [8:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic oe;
    busRead(a, d, oe);
    check({tag, " oe"}, {7'b0, oe}, 8'h01);
    check(tag, d, exp);
  endtask

  task automatic unlock();
    busWrite(9'h155, 8'hAA);
    busWrite(9'h0AA, 8'h55);
    busWrite(9'h155, 8'hA0);
  endtask

  task automatic clearPg();
    for (int i = 0; i < 128; i++) begin pv[i] = 1'b0; pb[i] = 8'h00; end
  endtask

  task automatic loadB(input logic [8:0] a, input logic [7:0] d);
    busWrite(a, d);
    pv[a[6:0]] = 1'b1; pb[a[6:0]] = d; lastPage = a[8:7];
  endtask

  task automatic applyPg();
    for (int i = 0; i < 128; i++)
      model[{lastPage, 7'(i)}] = pv[i] ? pb[i] : 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);

    // R2 reset state
    check("R2 oe after reset", {7'b0, dataOe}, 8'h00);
    readCheck("R2 erased 0", 9'h000, 8'hFF);
    readCheck("R2 erased 1ff", 9'h1FF, 8'hFF);

    // R1 no drive unless both low
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; waitCyc(4);
    check("R1 ce only oe", {7'b0, dataOe}, 8'h00);
    check("R1 ce only data", dataOut, 8'h00);
    ceN = 1'b1; oeN = 1'b0; waitCyc(4);
    check("R1 oe only oe", {7'b0, dataOe}, 8'h00);
    oeN = 1'b1; waitCyc(3);

    // R3 + R6 unprotected load, overwrite of offset 3
    clearPg();
    loadB(9'h003, 8'h12);
    loadB(9'h005, 8'h34);
    loadB(9'h003, 8'h56);
    waitCyc(LOAD_T + PROG_T + 20);
    applyPg();
    readCheck("R3 unprotected write", 9'h005, 8'h34);
    readCheck("R6 overwrite", 9'h003, 8'h56);

    // R4 unlock enables protection, full page 1
    unlock();
    clearPg();
    for (int i = 0; i < 128; i++) loadB({2'b01, 7'(i)}, 8'((i * 7 + 3) & 8'hFF));
    waitCyc(10);
    readCheck("R7 old data before commit", 9'h080, 8'hFF);
    waitCyc(LOAD_T + PROG_T + 20);
    applyPg();
    for (int i = 0; i < 128; i++)
      readCheck("R4 full page after unlock", {2'b01, 7'(i)}, model[{2'b01, 7'(i)}]);
    readCheck("R4 command byte not stored", 9'h155, 8'hFF);

    // R5 protected: plain write and aborted command ignored
    busWrite(9'h080, 8'h99);
    waitCyc(LOAD_T + PROG_T + 20);
    readCheck("R5 plain write ignored", 9'h080, model[9'h080]);
    busWrite(9'h155, 8'hAA);
    busWrite(9'h0AA, 8'h56);
    busWrite(9'h155, 8'hA0);
    busWrite(9'h081, 8'h99);
    waitCyc(LOAD_T + PROG_T + 20);
    readCheck("R5 aborted command ignored", 9'h081, model[9'h081]);

    // R8 last byte picks page; R10 status during program
    unlock();
    clearPg();
    loadB(9'h08A, 8'h11);
    loadB(9'h094, 8'h22);
    loadB(9'h19E, 8'h33);
    waitCyc(10);
    readCheck("R7 page3 still old", 9'h18A, 8'hFF);
    waitCyc(45);
    readCheck("R10 busy status", 9'h18A, 8'h80);
    waitCyc(LOAD_T + PROG_T + 20);
    applyPg();
    readCheck("R8 byte moved to page3", 9'h18A, 8'h11);
    readCheck("R8 second byte page3", 9'h194, 8'h22);
    readCheck("R8 page1 untouched", 9'h08A, model[9'h08A]);

    // R11 protection back after page write
    busWrite(9'h180, 8'h44);
    waitCyc(LOAD_T + PROG_T + 20);
    readCheck("R11 reprotected", 9'h180, 8'hFF);

    // R9 partial rewrite of page 1 fills with FF
    unlock();
    clearPg();
    loadB(9'h080, 8'h5A);
    waitCyc(LOAD_T + PROG_T + 20);
    applyPg();
    readCheck("R9 loaded byte", 9'h080, 8'h5A);
    readCheck("R9 unloaded byte", 9'h081, 8'hFF);

    // R10 writes during program discarded, status bit7 inverted
    unlock();
    clearPg();
    loadB(9'h000, 8'hC5);
    waitCyc(50);
    busWrite(9'h001, 8'h77);
    busRead(9'h001, d, oe);
    check("R10 status bit7 low", d, 8'h00);
    waitCyc(LOAD_T + PROG_T + 20);
    applyPg();
    readCheck("R10 write in program dropped", 9'h001, 8'hFF);

    // R12 + R1 exhaustive sweep of the array
    for (int i = 0; i < NBYTES; i++)
      readCheck("R12 R1 sweep", 9'(i), model[i]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule